// File: doc/BRIEF.md
# Dual-Clock FIFO with Almost-Full Flag

This block is a 64-word by 36-bit first-in first-out buffer. Its write port and its read port run on unrelated clocks. The write side drives a full indication and an active-low almost-full flag. Both are based on the fill level as the write domain currently sees it. The read side drives an empty indication and a registered data output.

The almost-full threshold comes from a 6-bit offset input X. The flag goes low when the buffer holds 64 − X words or more, and it is high at 63 − X words or fewer.

Reads happen in the other clock domain, so a read reaches the write side only through a two-stage synchroniser carrying a Gray-coded read pointer. As a result, the flag returns high on the second write-clock rising edge after the read. A write-clock edge that comes too close after the read edge cannot capture the new pointer. In that case the next write edge becomes the first synchronisation cycle. The same two-edge path carries writes toward the empty indication.

Top module: `dcf_afull_fifo`

## Requirements
- R1: While reset is low, and after it is released, `empty` is 1, `full` is 0, `afull_n` is 1 and `rd_data` is 0.
- R2: Words leave through `rd_data` in the order they were accepted, with all 36 bits intact. The data of an accepted read appears on `rd_data` after the read-clock rising edge that performs it.
- R3: `full` is 1 exactly when the write-side fill level (accepted writes minus synchronised reads) is 64. A write requested while `full` is 1 is ignored.
- R4: A read requested while `empty` is 1 is ignored: no word is consumed and `rd_data` keeps its value.
- R5: `afull_n` goes to 0 on the same write-clock edge at which an accepted write raises the write-side fill level to 64 − X, for any X from 0 to 63.
- R6: `afull_n` is 1 whenever the write-side fill level is 63 − X or less, and 0 whenever it is 64 − X or more.
- R7: After a read lowers the level to 63 − X, `afull_n` stays 0 on the first write-clock rising edge that follows the read edge. It goes to 1 on the second such edge.
- R8: After a write into an empty buffer, `empty` stays 1 on the first read-clock rising edge that follows the write edge. It goes to 0 on the second such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request, sampled on wr_clk rising edges |
| wr_data | input | 36 | Word to store |
| af_gap | input | 6 | Almost-full offset X (threshold 64 − X) |
| full | output | 1 | High when the write side sees 64 stored words |
| afull_n | output | 1 | Active-low almost-full flag, write-clock domain |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request, sampled on rd_clk rising edges |
| rd_data | output | 36 | Registered output word |
| empty | output | 1 | High when the read side sees no stored words |

## Verification
`afull_n` falls right after the write edge that reaches the threshold, and rises right after the second write edge that follows a read. `empty` falls right after the second read edge that follows a write. `rd_data` changes right after the read edge that consumes a word.

The behavioural reference model updates on the same edges as the design. Write-side results are compared on every falling edge of `wr_clk`, and read-side results on every falling edge of `rd_clk`. The two clock periods are chosen so that their rising edges never coincide. The directed latency checks count rising edges starting strictly after the causing edge, and sample 1 ns after each one.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s << 1) b = b ^ (b >> s);
    return b;
  endfunction

  // distance from a trailing pointer to a leading one, modulo 2**pw
  function automatic logic [31:0] ring_fill(input logic [31:0] ahead,
                                            input logic [31:0] behind,
                                            input int pw);
    return (ahead - behind) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter  int DEPTH = 64,
  parameter  int WIDTH = 36,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_go,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk)
    if (wr_go) mem[waddr] <= wdata;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] gap,
  input  logic [PW-1:0] rgray_seen,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_go,
  output logic          full,
  output logic          afull_n
);
  logic [PW-1:0] wbin, wbin_nx, rbin_seen, fill_w, thr;

  assign rbin_seen = PW'(gray_to_bin(32'(rgray_seen)));
  assign fill_w    = PW'(ring_fill(32'(wbin), 32'(rbin_seen), PW));
  assign thr       = PW'(DEPTH) - PW'(gap);
  assign full      = (fill_w == PW'(DEPTH));
  assign afull_n   = (fill_w < thr);
  assign wr_go     = wr_en & ~full;
  assign wbin_nx   = wbin + PW'(1);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin_to_gray(32'(wbin_nx)));
    end

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    fill_w <= PW'(DEPTH));
  assert_full_blocks_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wgray));
  assert_afull_on_write_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ($fell(afull_n) && $stable(gap)) |-> $past(wr_go));
  assert_afull_release_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ($rose(afull_n) && $stable(gap)) |-> (rgray_seen != $past(rgray_seen)));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_seen,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_go,
  output logic          empty
);
  logic [PW-1:0] rbin, rbin_nx, fill_r;

  assign empty   = (rgray == wgray_seen);
  assign rd_go   = rd_en & ~empty;
  assign rbin_nx = rbin + PW'(1);
  assign raddr   = rbin[AW-1:0];
  assign fill_r  = PW'(ring_fill(gray_to_bin(32'(wgray_seen)), 32'(rbin), PW));

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_go) begin
      rbin  <= rbin_nx;
      rgray <= PW'(bin_to_gray(32'(rbin_nx)));
    end

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    fill_r <= PW'(DEPTH));
  assert_gray_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  assert_empty_release_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(empty) |-> (wgray_seen != $past(wgray_seen)));
endmodule

// File: rtl/dcf_afull_fifo.sv
module dcf_afull_fifo #(
  parameter  int DEPTH = 64,
  parameter  int WIDTH = 36,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    af_gap,
  output logic             full,
  output logic             afull_n,
  input  logic             rd_clk,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  logic [PW-1:0] wgray, rgray, wgray_seen, rgray_seen;
  logic [AW-1:0] waddr, raddr;
  logic          wr_go, rd_go;

  dcf_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_seen));

  dcf_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_seen));

  dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .gap(af_gap),
    .rgray_seen(rgray_seen), .wgray(wgray), .waddr(waddr), .wr_go(wr_go),
    .full(full), .afull_n(afull_n));

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_seen(wgray_seen),
    .rgray(rgray), .raddr(raddr), .rd_go(rd_go), .empty(empty));

  dcf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wr_clk(wr_clk), .wr_go(wr_go), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_go(rd_go), .raddr(raddr),
    .rdata(rd_data));

  assert_empty_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_data));
endmodule

// File: tb/test_dcf_afull_fifo.sv
`timescale 1ns/1ps
module test_dcf_afull_fifo;
  logic        rst_n = 0, wr_clk = 0, rd_clk = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [35:0] wr_data = '0, rd_data;
  logic [5:0]  af_gap = 6'd4;
  logic        full, afull_n, empty;

  int checks = 0, errors = 0, seq = 0;
  bit done = 0;

  dcf_afull_fifo i_dcf_afull_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .af_gap(af_gap), .full(full), .afull_n(afull_n), .rd_clk(rd_clk),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  always #4 wr_clk = ~wr_clk;          // 125 MHz, rising at 4 + 8k
  initial begin                         // rising at 5.5 + 11k, never on a wr edge
    #5.5;
    forever begin rd_clk = 1; #5.5; rd_clk = 0; #5.5; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int wcnt, rcnt, rs1, rs2, ws1, ws2;
  logic [35:0] q[$];
  logic [35:0] exp_data;

  always @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wcnt = 0; rs1 = 0; rs2 = 0;
    end else begin
      if (wr_en && (wcnt - rs2) != 64) begin
        q.push_back(wr_data);
        wcnt = wcnt + 1;
      end
      rs2 = rs1;
      rs1 = rcnt;
    end

  always @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rcnt = 0; ws1 = 0; ws2 = 0; exp_data = '0;
    end else begin
      if (rd_en && rcnt != ws2) begin
        exp_data = q.pop_front();
        rcnt = rcnt + 1;
      end
      ws2 = ws1;
      ws1 = wcnt;
    end

  always @(negedge wr_clk)
    if (rst_n) begin
      chk(full == ((wcnt - rs2) == 64), "R3", "full", full, (wcnt - rs2) == 64);
      if ((wcnt - rs2) < (64 - int'(af_gap)))
        chk(afull_n == 1'b1, "R6", "afull_n below threshold", afull_n, 1);
      else
        chk(afull_n == 1'b0, "R6", "afull_n at/above threshold", afull_n, 0);
    end

  always @(negedge rd_clk)
    if (rst_n) begin
      chk(empty == (rcnt == ws2), "R4", "empty", empty, rcnt == ws2);
      chk(rd_data == exp_data, "R2", "rd_data order", rd_data, exp_data);
    end

  // ---------------- stimulus ----------------
  function automatic logic [35:0] pattern(input int k);
    return (36'(k) * 36'h9E3779B1) ^ {4'(k), 32'h0};
  endfunction

  task automatic write_n(input int n);
    repeat (n) begin
      @(negedge wr_clk); wr_en = 1; wr_data = pattern(seq); seq++;
    end
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic read_n(input int n);
    repeat (n) begin @(negedge rd_clk); rd_en = 1; end
    @(negedge rd_clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  initial begin
    #20;
    chk(empty == 1'b1,    "R1", "empty in reset",   empty,   1);
    chk(full == 1'b0,     "R1", "full in reset",    full,    0);
    chk(afull_n == 1'b1,  "R1", "afull_n in reset", afull_n, 1);
    chk(rd_data == 36'd0, "R1", "rd_data in reset", rd_data, 0);
    #10 rst_n = 1;
    #3;
    chk(empty && !full && afull_n, "R1", "state after release",
        {empty, full, afull_n}, 3'b101);

    // X = 4: fill to 60, flag low
    write_n(60); settle();
    chk(afull_n == 1'b0, "R5", "afull_n at 60 words, X=4", afull_n, 0);

    // one read, then count write edges (R7)
    @(negedge rd_clk); rd_en = 1;
    @(posedge rd_clk); rd_en <= 0;
    @(posedge wr_clk); #1;
    chk(afull_n == 1'b0, "R7", "afull_n after first wr edge", afull_n, 0);
    @(posedge wr_clk); #1;
    chk(afull_n == 1'b1, "R7", "afull_n after second wr edge", afull_n, 1);

    // one write back to 60: same-edge assertion (R5)
    @(negedge wr_clk); wr_en = 1; wr_data = pattern(seq); seq++;
    @(posedge wr_clk); wr_en <= 0; #1;
    chk(afull_n == 1'b0, "R5", "afull_n on reaching edge", afull_n, 0);

    // overfill: extra writes ignored (R3)
    write_n(10); settle();
    chk(full == 1'b1, "R3", "full after overfill", full, 1);

    // drain past empty (R4)
    read_n(80); settle();
    chk(empty == 1'b1, "R4", "empty after overdrain", empty, 1);
    chk(rd_data == exp_data, "R4", "rd_data held", rd_data, exp_data);
    chk(q.size() == 0, "R3", "exactly 64 words accepted", q.size(), 0);

    // empty release latency (R8)
    @(negedge wr_clk); wr_en = 1; wr_data = pattern(seq); seq++;
    @(posedge wr_clk); wr_en <= 0;
    @(posedge rd_clk); #1;
    chk(empty == 1'b1, "R8", "empty after first rd edge", empty, 1);
    @(posedge rd_clk); #1;
    chk(empty == 1'b0, "R8", "empty after second rd edge", empty, 0);
    read_n(1); settle();

    // X = 0: flag only at 64 words
    @(negedge wr_clk); af_gap = 6'd0;
    write_n(63); settle();
    chk(afull_n == 1'b1, "R6", "afull_n at 63 words, X=0", afull_n, 1);
    @(negedge wr_clk); wr_en = 1; wr_data = pattern(seq); seq++;
    @(posedge wr_clk); wr_en <= 0; #1;
    chk(afull_n == 1'b0, "R5", "afull_n at 64 words, X=0", afull_n, 0);
    chk(full == 1'b1, "R3", "full at 64 words", full, 1);
    read_n(70); settle();

    // X = 63: threshold of one word
    @(negedge wr_clk); af_gap = 6'd63;
    @(negedge wr_clk);
    chk(afull_n == 1'b1, "R6", "afull_n empty, X=63", afull_n, 1);
    @(negedge wr_clk); wr_en = 1; wr_data = pattern(seq); seq++;
    @(posedge wr_clk); wr_en <= 0; #1;
    chk(afull_n == 1'b0, "R5", "afull_n at 1 word, X=63", afull_n, 0);
    read_n(3); settle();

    // mixed traffic, X = 10
    @(negedge wr_clk); af_gap = 6'd10;
    fork
      repeat (3000) begin
        @(negedge wr_clk);
        wr_en = ($urandom_range(0, 99) < 60);
        wr_data = pattern(seq); seq++;
      end
      repeat (2200) begin
        @(negedge rd_clk);
        rd_en = ($urandom_range(0, 99) < 50);
      end
    join
    @(negedge wr_clk); wr_en = 0;
    @(negedge rd_clk); rd_en = 0;
    read_n(80); settle();
    chk(empty == 1'b1, "R2", "all words drained", empty, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule